// File: doc/BRIEF.md
# Triggered Port Burst Sequencer

The sequencer waits with all outputs quiet until a trigger arrives on a synchronous level input. Each rising edge of that level counts as one request. A request starts a burst of nine byte transfers to an 8-bit output port. For each transfer the block asks an upstream byte source for data using a request/valid handshake. It then drives the byte on the port and raises a strobe one cycle later, for a fixed number of cycles.

A one-bit sense input is sampled once per transfer. Only the last eight samples are kept. When the burst finishes, that byte goes into a small result FIFO that a host pops. Triggers that arrive while a burst is running are counted in a small queue, so each one starts a further burst straight after the current burst ends. Excess triggers and writes to a full FIFO are dropped, and each kind of loss sets its own sticky flag.

Top module: `trig_burst_seq`

## Requirements
- R1: While rst_ni is low, and after reset, port_o is 0. strobe_o, byte_req_o, res_full_o, res_ovf_o and trig_ovf_o are 0, and res_empty_o is 1.
- R2: With no pending trigger the block issues no byte request and no strobe. A low-to-high change of trig_i starts exactly one burst of 9 transfers, however long trig_i stays high.
- R3: In each transfer byte_req_o stays high until a cycle in which byte_vld_i is also high. In that cycle byte_i is taken into port_o. port_o then holds until the next accepted byte.
- R4: strobe_o rises on the clock edge after the one that updated port_o and stays high for exactly 16 cycles. port_o does not change while strobe_o is high, and no request is raised during a strobe.
- R5: sense_i is sampled on the clock edge at which strobe_o falls. The result byte holds the last 8 samples of the burst: the 2nd sample is in bit 0 and the 9th sample is in bit 7.
- R6: At the end of each burst the result byte is written into a 4-entry FIFO. res_o shows the oldest entry, and a high rd_i on a non-empty FIFO pops it. res_empty_o and res_full_o reflect the occupancy, and a pop on an empty FIFO has no effect.
- R7: A result written while the FIFO is full is dropped, and res_ovf_o goes high and stays high until reset.
- R8: The trigger queue counts the running burst plus pending requests, up to 4 in total. One request is consumed as a burst ends. A further burst then follows with no idle cycle, and the block goes idle only once the count is zero.
- R9: A trigger edge that arrives while the queue holds 4 requests, in a cycle with no consumption, is dropped. trig_ovf_o then goes high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Synchronous trigger level |
| byte_req_o | output | 1 | Request for the next byte |
| byte_vld_i | input | 1 | Byte source has data on byte_i |
| byte_i | input | 8 | Byte from the source |
| port_o | output | 8 | Output port |
| strobe_o | output | 1 | Port strobe |
| sense_i | input | 1 | External bit sampled per transfer |
| rd_i | input | 1 | Pop the result FIFO |
| res_o | output | 8 | Oldest result byte |
| res_empty_o | output | 1 | Result FIFO empty |
| res_full_o | output | 1 | Result FIFO full |
| res_ovf_o | output | 1 | Sticky result overflow |
| trig_ovf_o | output | 1 | Sticky trigger overflow |

## Verification
The bench holds trig_i high far longer than a burst. A level-sensitive start would show up as extra strobes beyond nine. It fires five short pulses during one burst. A queue that lost requests, or that accepted the fifth one, would produce a burst count other than four or leave trig_ovf_o clear. Each transfer gets a different sense bit, so an off-by-one in the sampling edge or in the bit order gives a wrong result byte. The byte source delay is varied to test the handshake, and one burst is run into a full FIFO, which must leave the stored four entries intact and raise res_ovf_o.

// File: rtl/tbs_pkg.sv
package tbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_SETTLE,
    ST_STRB,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/tbs_trig_queue.sv
module tbs_trig_queue #(
  parameter int DEPTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic pop_i,
  output logic pend_o,
  output logic more_o,
  output logic ovf_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          trig_q;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          edge_s, full_s, push_ok;

  assign edge_s  = trig_i & ~trig_q;
  assign full_s  = (cnt_q == CW'(DEPTH));
  assign push_ok = edge_s & (~full_s | pop_i);

  always_comb begin
    cnt_n = cnt_q;
    if (push_ok) cnt_n = cnt_n + CW'(1);
    if (pop_i && cnt_n != '0) cnt_n = cnt_n - CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= 1'b0;
      cnt_q  <= '0;
      ovf_o  <= 1'b0;
    end else begin
      trig_q <= trig_i;
      cnt_q  <= cnt_n;
      if (edge_s && full_s && !pop_i) ovf_o <= 1'b1;
    end
  end

  assign pend_o = (cnt_q != '0);
  // count after this cycle's pop: decides back-to-back burst
  assign more_o = (cnt_n != '0);
endmodule

// File: rtl/tbs_res_fifo.sv
module tbs_res_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wd_i,
  input  logic         rd_i,
  output logic [W-1:0] rd_o,
  output logic         empty_o,
  output logic         full_o,
  output logic         ovf_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          wr_ok, rd_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign wr_ok   = wr_i & ~full_o;
  assign rd_ok   = rd_i & ~empty_o;
  assign rd_o    = mem[rp_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_o <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (wr_ok) begin
        mem[wp_q] <= wd_i;
        wp_q      <= nxt(wp_q);
      end
      if (rd_ok) rp_q <= nxt(rp_q);
      if (wr_ok && !rd_ok) cnt_q <= cnt_q + CW'(1);
      else if (rd_ok && !wr_ok) cnt_q <= cnt_q - CW'(1);
      if (wr_i && full_o) ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/tbs_burst_ctrl.sv
module tbs_burst_ctrl
  import tbs_pkg::*;
#(
  parameter int W     = 8,
  parameter int STEPS = 9,
  parameter int SLEN  = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pend_i,
  input  logic         more_i,
  input  logic         byte_vld_i,
  input  logic [W-1:0] byte_i,
  input  logic         sense_i,
  output logic         byte_req_o,
  output logic [W-1:0] port_o,
  output logic         strobe_o,
  output logic         done_o,
  output logic [W-1:0] res_o
);
  localparam int SW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam int LW = (SLEN > 1) ? $clog2(SLEN) : 1;

  seq_state_e    st_q;
  logic [SW-1:0] step_q;
  logic [LW-1:0] len_q;
  logic [W-1:0]  shr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
      len_q  <= '0;
      shr_q  <= '0;
      port_o <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (pend_i) begin
          st_q   <= ST_REQ;
          step_q <= '0;
          shr_q  <= '0;
        end
        ST_REQ: if (byte_vld_i) begin
          port_o <= byte_i;
          st_q   <= ST_SETTLE;
        end
        ST_SETTLE: begin
          len_q <= '0;
          st_q  <= ST_STRB;
        end
        ST_STRB: begin
          if (len_q == LW'(SLEN - 1)) begin
            shr_q <= {sense_i, shr_q[W-1:1]};
            if (step_q == SW'(STEPS - 1)) st_q <= ST_DONE;
            else begin
              step_q <= step_q + SW'(1);
              st_q   <= ST_REQ;
            end
          end else begin
            len_q <= len_q + LW'(1);
          end
        end
        ST_DONE: begin
          if (more_i) begin
            st_q   <= ST_REQ;
            step_q <= '0;
            shr_q  <= '0;
          end else begin
            st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign byte_req_o = (st_q == ST_REQ);
  assign strobe_o   = (st_q == ST_STRB);
  assign done_o     = (st_q == ST_DONE);
  assign res_o      = shr_q;
endmodule

// File: rtl/trig_burst_seq.sv
module trig_burst_seq #(
  parameter int W        = 8,
  parameter int STEPS    = 9,
  parameter int SLEN     = 16,
  parameter int TQ_DEPTH = 4,
  parameter int RF_DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         trig_i,
  output logic         byte_req_o,
  input  logic         byte_vld_i,
  input  logic [W-1:0] byte_i,
  output logic [W-1:0] port_o,
  output logic         strobe_o,
  input  logic         sense_i,
  input  logic         rd_i,
  output logic [W-1:0] res_o,
  output logic         res_empty_o,
  output logic         res_full_o,
  output logic         res_ovf_o,
  output logic         trig_ovf_o
);
  logic         pend, more, done;
  logic [W-1:0] shr;

  tbs_trig_queue #(.DEPTH(TQ_DEPTH)) u_tq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig_i),
    .pop_i  (done),
    .pend_o (pend),
    .more_o (more),
    .ovf_o  (trig_ovf_o)
  );

  tbs_burst_ctrl #(.W(W), .STEPS(STEPS), .SLEN(SLEN)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pend_i     (pend),
    .more_i     (more),
    .byte_vld_i (byte_vld_i),
    .byte_i     (byte_i),
    .sense_i    (sense_i),
    .byte_req_o (byte_req_o),
    .port_o     (port_o),
    .strobe_o   (strobe_o),
    .done_o     (done),
    .res_o      (shr)
  );

  tbs_res_fifo #(.W(W), .DEPTH(RF_DEPTH)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (done),
    .wd_i    (shr),
    .rd_i    (rd_i),
    .rd_o    (res_o),
    .empty_o (res_empty_o),
    .full_o  (res_full_o),
    .ovf_o   (res_ovf_o)
  );
endmodule

// File: rtl/tbs_checker.sv
module tbs_checker #(
  parameter int W    = 8,
  parameter int SLEN = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] port_o,
  input logic         strobe_o,
  input logic         byte_req_o,
  input logic         res_empty_o,
  input logic         res_full_o,
  input logic         res_ovf_o,
  input logic         trig_ovf_o
);
  localparam int RW = $clog2(SLEN + 2);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else         run_q <= strobe_o ? run_q + RW'(1) : '0;
  end

  p_port_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> (!strobe_o || $stable(port_o)));
  p_no_req_in_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(byte_req_o && strobe_o));
  p_strobe_short_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> (run_q < RW'(SLEN)));
  p_strobe_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_o && run_q != '0) |-> (run_q == RW'(SLEN)));
  p_flags_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(res_empty_o && res_full_o));
  p_res_ovf_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_ovf_o |=> res_ovf_o);
  p_trig_ovf_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_ovf_o |=> trig_ovf_o);
endmodule

bind trig_burst_seq tbs_checker #(.W(W), .SLEN(SLEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .port_o      (port_o),
  .strobe_o    (strobe_o),
  .byte_req_o  (byte_req_o),
  .res_empty_o (res_empty_o),
  .res_full_o  (res_full_o),
  .res_ovf_o   (res_ovf_o),
  .trig_ovf_o  (trig_ovf_o)
);

// File: tb/sim_trig_burst_seq.sv
`timescale 1ns/1ps
module sim_trig_burst_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       trig_i = 1'b0;
  logic       byte_req_o;
  logic       byte_vld_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic [7:0] port_o;
  logic       strobe_o;
  logic       sense_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] res_o;
  logic       res_empty_o, res_full_o, res_ovf_o, trig_ovf_o;

  always #10 clk_i = ~clk_i;

  trig_burst_seq u0 (.*);

  int total = 0, bad = 0;
  int strobes = 0, xfer_n = 0, wait_c = 0, run = 0;
  int bursts = 0, fifo_model = 0;
  bit prev_strobe = 0, finished = 0;
  logic [7:0] prev_port = '0;
  logic [7:0] exp_port_q[$];
  logic [7:0] exp_res_q[$];

  function automatic logic [8:0] pat_of(int b);
    return 9'(b * 37 + 91) ^ 9'h0b5;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // byte source, delay varies 0..3 cycles
  initial forever begin
    @(negedge clk_i);
    if (!rst_ni) begin
      byte_vld_i = 0;
    end else if (byte_vld_i) begin
      byte_vld_i = 0;
    end else if (byte_req_o) begin
      if (wait_c >= xfer_n % 4) begin
        byte_i = 8'(xfer_n * 29 + 3);
        exp_port_q.push_back(byte_i);
        byte_vld_i = 1;
        xfer_n++;
        wait_c = 0;
      end else wait_c++;
    end
  end

  // monitor: port data, strobe shape, sense stimulus
  initial forever begin
    @(negedge clk_i);
    if (rst_ni) begin
      if (byte_req_o) chk("R3 port hold while requesting", port_o, prev_port);
      if (strobe_o && !prev_strobe) begin
        logic [8:0] p;
        chk("R4 strobe after port settled", port_o, prev_port);
        if (exp_port_q.size() == 0) chk("R3 unexpected strobe", 1, 0);
        else chk("R3 port data", port_o, exp_port_q.pop_front());
        p = pat_of(strobes / 9);
        sense_i = p[strobes % 9];
        strobes++;
        run = 0;
      end
      if (strobe_o) run++;
      if (!strobe_o && prev_strobe) chk("R4 strobe length", run, 16);
    end
    prev_strobe = strobe_o;
    prev_port = port_o;
  end

  task automatic pulse(int hi, bit expect_burst);
    if (expect_burst) begin
      logic [8:0] p;
      p = pat_of(bursts);
      bursts++;
      if (fifo_model < 4) begin
        exp_res_q.push_back(p[8:1]);
        fifo_model++;
      end
    end
    @(negedge clk_i); trig_i = 1;
    repeat (hi) @(negedge clk_i);
    trig_i = 0;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic wait_idle();
    int q = 0;
    while (q < 40) begin
      @(negedge clk_i);
      if (byte_req_o || strobe_o) q = 0; else q++;
    end
  endtask

  task automatic read_res();
    @(negedge clk_i);
    chk("R6 not empty before read", res_empty_o, 0);
    if (exp_res_q.size() == 0) chk("R6 no result expected", 1, 0);
    else chk("R5 result byte", res_o, exp_res_q.pop_front());
    rd_i = 1;
    @(negedge clk_i);
    rd_i = 0;
    fifo_model--;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 values during reset
    chk("R1 port", port_o, 0);
    chk("R1 strobe", strobe_o, 0);
    chk("R1 req", byte_req_o, 0);
    chk("R1 empty", res_empty_o, 1);
    chk("R1 full", res_full_o, 0);
    chk("R1 flags", {res_ovf_o, trig_ovf_o}, 0);
    rst_ni = 1;
    repeat (30) @(negedge clk_i);
    chk("R2 idle no request", byte_req_o, 0);
    chk("R2 idle no strobe", strobes, 0);

    // R2 long level starts one burst
    pulse(500, 1);
    wait_idle();
    chk("R2 one burst of 9", strobes, 9);
    chk("R6 result stored", res_empty_o, 0);
    read_res();
    chk("R6 empty after pop", res_empty_o, 1);

    // R8 queued triggers, R9 fifth dropped
    for (int i = 0; i < 5; i++) pulse(3, i < 4);
    wait_idle();
    chk("R8 four back-to-back bursts", strobes, 45);
    chk("R9 trigger overflow flag", trig_ovf_o, 1);
    chk("R6 fifo full", res_full_o, 1);
    chk("R7 no overflow yet", res_ovf_o, 0);
    chk("R8 idle after queue empty", byte_req_o, 0);

    // R7 burst into full fifo
    pulse(3, 1);
    wait_idle();
    chk("R7 burst ran", strobes, 54);
    chk("R7 result overflow flag", res_ovf_o, 1);
    for (int i = 0; i < 4; i++) read_res();
    chk("R6 empty after draining", res_empty_o, 1);
    rd_i = 1;
    @(negedge clk_i);
    rd_i = 0;
    @(negedge clk_i);
    chk("R6 pop on empty keeps empty", res_empty_o, 1);
    chk("R6 pop on empty not full", res_full_o, 0);
    chk("R7 flag sticky", res_ovf_o, 1);
    chk("R9 flag sticky", trig_ovf_o, 1);
    chk("R3 no stray port data", exp_port_q.size(), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule